// File: doc/BRIEF.md
# Priority Telecommand Input Selector

This block picks one of six serial telecommand inputs and hands it to a single downstream decoder. Each input presents an active flag and a one-cycle bit-clock strobe. The decoder reports back two pulses: one when it sees a start sequence, and one when a tail sequence or a rejected codeblock ends the frame. The selector publishes the chosen channel index with a valid flag. It also raises a one-cycle abandon pulse whenever a higher-priority input takes the decoder away from a channel that was still in use.

Inputs 0 and 1 are privileged. Input 0 pre-empts every other input. Input 1 pre-empts inputs 2 to 5 but never input 0. Inputs 2 to 5 are peers and are served first-come. Two watchdogs guard the selected input: a bit-clock idle timer for each channel and a start-sequence timer for the current selection. Both count ticks of a shared free-running prescaler. When either watchdog expires, the input is released and locked out until its active flag falls.

Top module: `tc_input_selector`

## Requirements
- R1: After synchronous reset, sel_valid_o and abandon_o are 0 and sel_idx_o is 0.
- R2: In the search state (sel_valid_o low), the eligible input with the lowest index is selected on the next clock edge. An input is eligible when its active flag is high and it is not locked out. Index 0 therefore always wins and index 1 beats 2 to 5.
- R3: While any other input is selected, an eligible input 0 takes the selection on the next edge, and abandon_o is high in that same cycle.
- R4: While one of inputs 2 to 5 is selected and input 0 is not eligible, an eligible input 1 takes the selection on the next edge with abandon_o high. Input 1 never displaces input 0.
- R5: Among inputs 2 to 5, ties in one cycle go to the lowest index. A selected peer is kept when other peers become active.
- R6: If the selected input's active flag is low, or tail_or_reject_i is high, the next cycle is in search (valid low). The input remains eligible afterwards.
- R7: The prescaler counts cycles from reset and ticks in each cycle where its PRESC_W low bits are all ones. The idle count of each input is cleared by its strobe or while it is inactive, and otherwise advances on ticks up to CLK_LIMIT. When the selected input's count equals CLK_LIMIT, the next cycle is in search.
- R8: The start count is cleared while nothing is selected, on start_seen_i, and when a new selection is loaded. Otherwise it advances on ticks up to ACT_LIMIT. When it equals ACT_LIMIT, the next cycle is in search.
- R9: An input released by R7 or R8 is not selected again until its active flag has been low for at least one cycle.
- R10: abandon_o is high only in the first cycle of a pre-emption by R3 or R4, never on a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tc_active_i | input | 6 | Active flag per input |
| bit_clk_i | input | 6 | One-cycle bit-clock edge strobe per input |
| start_seen_i | input | 1 | Decoder saw a start sequence on the selected input |
| tail_or_reject_i | input | 1 | Decoder saw a tail sequence or rejected a codeblock |
| sel_idx_o | output | 3 | Index of the selected input |
| sel_valid_o | output | 1 | An input is selected |
| abandon_o | output | 1 | One-cycle pulse on pre-emption |

## Verification
Checked on every cycle: abandon_o appears only with a valid selection of input 0 or 1, a lost active flag leads to search, input 0 displaces any other selection, lockouts disappear after the flag falls, and the idle timers saturate and clear as stated. The bench's scenarios cover the rest. Those scenarios include the first-come service of peers, the timeout windows measured in prescaler ticks, the persistence of a lockout while the flag stays high, and the correct reselection after each kind of release. A cycle-level reference model computed from the requirements is compared against the outputs after every edge.

// File: rtl/tcsel_pkg.sv
// Shared types for the telecommand input selector.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package tcsel_pkg;

    // Reason a selection ends in a given cycle.
    typedef enum logic [1:0] {
        END_NONE   = 2'd0,
        END_SEARCH = 2'd1,
        END_LOCK   = 2'd2
    } end_kind_e;

endpackage

// File: rtl/tcsel_prescaler.sv
// Free-running prescaler. Emits a one-cycle tick every 2**PRESC_W cycles,
// in the cycle where the counter holds all ones.
// Assumes: PRESC_W >= 1.
module tcsel_prescaler #(
    parameter int PRESC_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    logic [PRESC_W-1:0] cnt_q;

    // Advance the counter every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = &cnt_q;
endmodule

// File: rtl/tcsel_idle_timer.sv
// Saturating tick counter. It is cleared by clear_i and reports expiry once
// LIMIT ticks have passed without a clear.
// Assumes: LIMIT >= 1; tick_i is a one-cycle pulse.
module tcsel_idle_timer #(
    parameter int LIMIT = 61
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Count ticks since the last clear, stopping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (clear_i)                  cnt_q <= '0;
        else if (tick_i && (cnt_q != LIM)) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == LIM);

    // R7 / R8: a clear always removes the expiry on the next cycle.
    assert_clear_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !expired_o);

    // R7 / R8: once expired, the timer holds until cleared.
    assert_expiry_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !clear_i) |=> expired_o);
endmodule

// File: rtl/tcsel_arbiter.sv
// Selection state machine: search, hold, pre-emption and timeout lockout.
// Eligible = active and not locked. The lowest eligible index wins, so
// inputs 0 and 1 outrank the peers 2..N-1.
// Assumes: N >= 3; expiry inputs come from registered timers.
module tcsel_arbiter
    import tcsel_pkg::*;
#(
    parameter int N     = 6,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     act_i,
    input  logic [N-1:0]     clk_exp_i,
    input  logic             st_exp_i,
    input  logic             tail_rej_i,
    output logic             load_o,
    output logic [IDX_W-1:0] sel_idx_o,
    output logic             sel_valid_o,
    output logic             abandon_o
);
    logic [IDX_W-1:0] sel_q;
    logic             valid_q;
    logic             abandon_q;
    logic [N-1:0]     lock_q;

    logic [N-1:0]     elig;
    logic [IDX_W-1:0] pick;
    logic             cur_act;
    logic             cur_to;
    end_kind_e        end_kind;
    logic             preempt;

    // Find the lowest eligible index.
    always_comb begin
        elig = act_i & ~lock_q;
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) pick = IDX_W'(i);
        end
    end

    // Decide whether the current selection ends or is pre-empted.
    always_comb begin
        cur_act  = act_i[sel_q];
        cur_to   = clk_exp_i[sel_q] | st_exp_i;
        end_kind = END_NONE;
        if (valid_q) begin
            if (!cur_act || tail_rej_i) end_kind = END_SEARCH;
            else if (cur_to)            end_kind = END_LOCK;
        end
        preempt = valid_q && (end_kind == END_NONE) &&
                  ((sel_q != '0 && elig[0]) ||
                   (sel_q > IDX_W'(1) && elig[1]));
        load_o  = preempt || (!valid_q && (|elig));
    end

    // Update the selection and the abandon pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q     <= '0;
            valid_q   <= 1'b0;
            abandon_q <= 1'b0;
        end else begin
            abandon_q <= preempt;
            if (end_kind != END_NONE) begin
                valid_q <= 1'b0;
            end else if (load_o) begin
                valid_q <= 1'b1;
                sel_q   <= pick;
            end
        end
    end

    // One lockout flag per input: set on a timeout release, cleared when inactive.
    for (genvar g = 0; g < N; g++) begin : g_lock
        always_ff @(posedge clk) begin
            if (!rst_n)                                            lock_q[g] <= 1'b0;
            else if (!act_i[g])                                    lock_q[g] <= 1'b0;
            else if (end_kind == END_LOCK && sel_q == IDX_W'(g))   lock_q[g] <= 1'b1;
        end
    end

    assign sel_idx_o   = sel_q;
    assign sel_valid_o = valid_q;
    assign abandon_o   = abandon_q;

    // R10: abandon only accompanies a new selection of input 0 or 1.
    assert_abandon_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abandon_q |-> (valid_q && sel_q <= IDX_W'(1)));

    // R6: losing the active flag always leads to search.
    assert_drop_to_search_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !act_i[sel_q]) |=> !valid_q);

    // R3: an eligible input 0 displaces a held lower input.
    assert_ch0_preempts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && sel_q != '0 && act_i[sel_q] && !tail_rej_i && !cur_to &&
         act_i[0] && !lock_q[0]) |=> (valid_q && sel_q == '0 && abandon_q));

    // R9: no lockout survives a cycle in which its flag was low.
    assert_lock_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q & ~$past(act_i)) == '0);
endmodule

// File: rtl/tc_input_selector.sv
// Top of the telecommand input selector. It ties together the prescaler,
// one bit-clock idle timer per input, the start-sequence timer of the
// current selection, and the arbiter.
// Assumes: strobes and pulses are one cycle wide and synchronous to clk.
module tc_input_selector #(
    parameter int NUM_CH    = 6,
    parameter int PRESC_W   = 16,
    parameter int CLK_LIMIT = 61,
    parameter int ACT_LIMIT = 5101
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         tc_active_i,
    input  logic [NUM_CH-1:0]         bit_clk_i,
    input  logic                      start_seen_i,
    input  logic                      tail_or_reject_i,
    output logic [$clog2(NUM_CH)-1:0] sel_idx_o,
    output logic                      sel_valid_o,
    output logic                      abandon_o
);
    localparam int IDX_W = $clog2(NUM_CH);

    logic              tick;
    logic [NUM_CH-1:0] clk_exp;
    logic              st_exp;
    logic              load;

    tcsel_prescaler #(.PRESC_W(PRESC_W)) i_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    // One idle timer per input, cleared by its strobe or while inactive.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_idle
        tcsel_idle_timer #(.LIMIT(CLK_LIMIT)) i_idle (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_i   (!tc_active_i[g] || bit_clk_i[g]),
            .tick_i    (tick),
            .expired_o (clk_exp[g])
        );
    end

    // Start-sequence timer of the current selection.
    tcsel_idle_timer #(.LIMIT(ACT_LIMIT)) i_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (!sel_valid_o || start_seen_i || load),
        .tick_i    (tick),
        .expired_o (st_exp)
    );

    tcsel_arbiter #(.N(NUM_CH), .IDX_W(IDX_W)) i_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (tc_active_i),
        .clk_exp_i   (clk_exp),
        .st_exp_i    (st_exp),
        .tail_rej_i  (tail_or_reject_i),
        .load_o      (load),
        .sel_idx_o   (sel_idx_o),
        .sel_valid_o (sel_valid_o),
        .abandon_o   (abandon_o)
    );
endmodule

// File: tb/test_tc_input_selector.sv
// Bench for tc_input_selector: directed corner cases, then seeded random
// traffic. A cycle-level reference model built from the requirements is
// checked after every edge.
module test_tc_input_selector;
    localparam int N  = 6;
    localparam int PW = 2;
    localparam int CL = 3;
    localparam int AL = 6;
    localparam int TP = 1 << PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] act = '0;
    logic [N-1:0] stb = '0;
    logic start = 1'b0;
    logic trej = 1'b0;
    logic [2:0] sel_idx;
    logic sel_valid;
    logic abandon;

    int n_run = 0;
    int n_fail = 0;

    // reference model state
    int m_presc;
    int m_clk[N];
    int m_st;
    bit m_lock[N];
    bit m_valid;
    int m_idx;
    bit m_ab;
    string m_tag;

    always #2 clk = ~clk;

    tc_input_selector #(.NUM_CH(N), .PRESC_W(PW), .CLK_LIMIT(CL), .ACT_LIMIT(AL))
    i_tc_input_selector (
        .clk(clk), .rst_n(rst_n), .tc_active_i(act), .bit_clk_i(stb),
        .start_seen_i(start), .tail_or_reject_i(trej),
        .sel_idx_o(sel_idx), .sel_valid_o(sel_valid), .abandon_o(abandon)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int got, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int lowest_elig();
        for (int i = 0; i < N; i++) if (act[i] && !m_lock[i]) return i;
        return -1;
    endfunction

    // Next model state from the current state and the driven inputs.
    task automatic model_step();
        bit tick = (m_presc == TP - 1);
        bit ends_s = 0, ends_l = 0, pre = 0, take;
        int p = lowest_elig();
        m_tag = "R5";
        if (m_valid) begin
            if (!act[m_idx] || trej) begin ends_s = 1; m_tag = "R6"; end
            else if (m_clk[m_idx] == CL) begin ends_l = 1; m_tag = "R7"; end
            else if (m_st == AL) begin ends_l = 1; m_tag = "R8"; end
        end
        if (m_valid && !ends_s && !ends_l && p >= 0 && p < m_idx && p <= 1) begin
            pre = 1; m_tag = (p == 0) ? "R3" : "R4";
        end
        take = pre || (!m_valid && p >= 0);
        if (!m_valid && p >= 0) m_tag = "R2";
        for (int i = 0; i < N; i++) begin
            if (!act[i]) m_lock[i] = 0;
            else if (ends_l && m_idx == i) m_lock[i] = 1;
        end
        if (!m_valid || start || take) m_st = 0;
        else if (tick && m_st < AL) m_st++;
        for (int i = 0; i < N; i++) begin
            if (!act[i] || stb[i]) m_clk[i] = 0;
            else if (tick && m_clk[i] < CL) m_clk[i]++;
        end
        m_ab = pre;
        if (ends_s || ends_l) m_valid = 0;
        else if (take) begin m_valid = 1; m_idx = p; end
        m_presc = (m_presc + 1) % TP;
    endtask

    // Inputs are set at a falling edge; advance one edge and compare.
    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(sel_valid == m_valid, m_tag, "valid", sel_valid, m_valid);
        check(abandon == m_ab, "R10", "abandon", abandon, m_ab);
        if (m_valid) check(sel_idx == m_idx, m_tag, "index", sel_idx, m_idx);
    endtask

    // Strobe every active input except those in mask.
    function automatic logic [N-1:0] strobes(input logic [N-1:0] mask);
        return act & ~mask;
    endfunction

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        m_presc = 0; m_st = 0; m_valid = 0; m_idx = 0; m_ab = 0;
        for (int i = 0; i < N; i++) begin m_clk[i] = 0; m_lock[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(sel_valid == 0, "R1", "valid", sel_valid, 0);
        check(abandon == 0, "R1", "abandon", abandon, 0);
        check(sel_idx == 0, "R1", "index", sel_idx, 0);

        // R5: simultaneous peers go to the lowest index
        start = 1;
        act = 6'b011000; stb = strobes('0); step();
        check(sel_idx == 3 && sel_valid, "R5", "tie index", sel_idx, 3);
        act = 6'b011100; stb = strobes('0); step();
        check(sel_idx == 3, "R5", "kept peer", sel_idx, 3);
        // R4: input 1 pre-empts a peer
        act = 6'b011110; stb = strobes('0); step();
        check(sel_idx == 1 && abandon, "R4", "preempt by 1", sel_idx, 1);
        stb = strobes('0); step();
        check(abandon == 0, "R10", "abandon width", abandon, 0);
        // R3: input 0 pre-empts input 1
        act = 6'b011111; stb = strobes('0); step();
        check(sel_idx == 0 && abandon, "R3", "preempt by 0", sel_idx, 0);
        // R6: tail/reject goes to search, then reselects
        trej = 1; stb = strobes('0); step();
        check(sel_valid == 0, "R6", "search after tail", sel_valid, 0);
        trej = 0; stb = strobes('0); step();
        check(sel_valid && sel_idx == 0, "R6", "reselect", sel_idx, 0);
        // R6: flag drop
        act = 6'b011110; stb = strobes('0); step();
        check(sel_valid == 0, "R6", "search after drop", sel_valid, 0);
        stb = strobes('0); step();
        check(sel_idx == 1, "R2", "priority pick", sel_idx, 1);

        // R7: starve input 1's bit clock
        n = 0;
        while (sel_valid && n < 60) begin stb = strobes(6'b000010); step(); n++; end
        check(n >= (CL - 1) * TP + 1 && n <= CL * TP + 2, "R7", "clock timeout cycles",
              n, CL * TP);
        stb = strobes('0); step();
        check(sel_idx == 2 && !abandon, "R9", "locked input skipped", sel_idx, 2);
        for (int k = 0; k < 8; k++) begin
            stb = strobes('0); step();
            check(sel_idx == 2, "R9", "lock holds", sel_idx, 2);
        end
        act = 6'b011100; stb = strobes('0); step();
        act = 6'b011110; stb = strobes('0); step();
        check(sel_idx == 1 && abandon, "R9", "lock released", sel_idx, 1);

        // R8: no start sequences
        start = 0; n = 0;
        while (sel_valid && n < 60) begin stb = strobes('0); step(); n++; end
        check(n >= (AL - 1) * TP + 1 && n <= AL * TP + 2, "R8", "start timeout cycles",
              n, AL * TP);
        start = 1; stb = strobes('0); step();
        check(sel_idx == 2, "R9", "locked after start timeout", sel_idx, 2);

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(99) < 2) act[i] = ~act[i];
                stb[i] = act[i] && ($urandom_range(7) < 1 + (i % 4));
            end
            start = ($urandom_range(11) == 0);
            trej  = ($urandom_range(49) == 0);
            step();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule